// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns parallel characters from a processor write port into a serial bit stream on a single output line. A character written by the processor lands in a one-entry holding buffer. From there it moves into a shift register, which sends it one bit per baud period. While a character is shifting out, the processor can already load the next one. The transmitter reports two flags. `tx_rdy` means the holding buffer can accept a character. `tx_empty` means no data character is left anywhere in the transmitter.

There are two line disciplines. In asynchronous mode each character is framed by a start bit, an optional parity bit and one or two stop bits. The bit period is 1, 16 or 64 transmit-clock ticks. In synchronous mode a character is sent as its data bits, plus parity if enabled, with no framing bits. One bit goes out per transmit-clock tick. When no data is waiting, the configured fill character is sent instead, so the line never goes quiet while enabled.

A new character starts only when the enable input is set and the active-low clear-to-send input is low. The transmit clock reaches the block as a one-cycle enable pulse, `txc_tick`, in the system clock domain. All configuration arrives on static inputs. Reset is synchronous and active high.

Top module: `dbuf_serial_tx`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `txd` is 1, `tx_rdy` is 1 and `tx_empty` is 1. Any character in the holding buffer or in the shifter is dropped.
- R2: The transmit bit rate is set as follows.
  - In asynchronous mode, `cfg_factor` gives the number of `txc_tick` pulses per bit: 0 gives 1, 1 gives 16, and 2 or 3 give 64.
  - Ticks are counted from reset by a free-running divider.
  - In synchronous mode every `txc_tick` is one bit, and `cfg_factor` is ignored.
- R3: An asynchronous frame is sent in this order:
  - one start bit at 0;
  - then 5+`cfg_len` data bits, LSB first;
  - then a parity bit if `cfg_par_en` is 1. With `cfg_par_odd`=0 the parity bit is the XOR of the data bits; with `cfg_par_odd`=1 it is that XOR inverted;
  - then one stop bit at 1, or two if `cfg_two_stop` is 1.
- R4: A write (`wr_stb` high) is accepted only while `tx_rdy` is 1. After an accepted write, `tx_rdy` is 0 on the next cycle. A write while `tx_rdy` is 0 is ignored and never sent.
- R5: Hand-over from the holding buffer to the shifter works as follows:
  - A held character moves into the shifter on the first baud tick at which the shifter is idle or ending the last bit of a frame.
  - `tx_rdy` returns to 1 on that tick.
  - A character held before a frame ends starts on the very next bit period, with no idle bit between the frames.
- R6: A character starts only when `tx_en` is 1 and `cts_n` is 0. Otherwise `txd` stays at 1, and a written character stays held with `tx_rdy` at 0.
- R7: If `cts_n` rises or `tx_en` falls during a character, that character is finished completely. The next one is held back until both conditions permit again.
- R8: In asynchronous mode, `tx_empty` is 1 exactly when the holding buffer is empty and the shifter is idle. While `tx_empty` is 1, `txd` is 1.
- R9: Synchronous mode works as follows:
  - A character is 5+`cfg_len` data bits, LSB first, plus the R3 parity bit if enabled, with no start or stop bit.
  - When enabled and no data is held, `sync_char` is sent, framed the same way.
  - Characters follow each other with no gap.
  - `tx_empty` is 1 whenever the holding buffer is empty and the shifter is idle or sending the fill character.
- R10: `txd` changes only on a baud tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| txc_tick | input | 1 | One-cycle pulse per transmit-clock period |
| cfg_sync | input | 1 | 1 selects synchronous mode |
| cfg_factor | input | 2 | Asynchronous clock-to-bit factor select |
| cfg_len | input | 2 | Character length select, 5+value bits |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 selects odd parity |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| sync_char | input | 8 | Fill character for synchronous mode |
| tx_en | input | 1 | Transmit enable |
| cts_n | input | 1 | Clear to send, active low |
| wr_stb | input | 1 | Character write strobe |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial data out, idles at 1 |
| tx_rdy | output | 1 | Holding buffer empty |
| tx_empty | output | 1 | No data character left to send |

## Verification
The assertions check these properties on every cycle:
- the line moves only on a baud tick;
- an accepted write always drops `tx_rdy`;
- `tx_rdy` returns only on a tick;
- an idle shifter keeps the line at mark while blocked;
- an empty asynchronous transmitter always shows mark.

Other behaviour can only be shown by the bench's scenarios:
- the exact frame contents: bit order, parity polarity and stop count;
- the bit period under each factor;
- back-to-back frames with no gap;
- the loss of a write made while full;
- a character finishing after clear-to-send drops;
- the placement of a data character among fill characters.

// File: rtl/dbtx_pkg.sv
package dbtx_pkg;

    parameter int CHAR_W   = 8;
    parameter int LEN_BASE = 5;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_START,
        SH_DATA,
        SH_PAR,
        SH_STOP1,
        SH_STOP2
    } sh_state_e;

    typedef struct packed {
        logic       sync_mode;
        logic [1:0] len_sel;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } frame_cfg_t;

    // transmit-clock ticks per bit in asynchronous mode
    function automatic int unsigned baud_div(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 16;
            default: return 64;
        endcase
    endfunction

    function automatic logic [CHAR_W-1:0] char_mask(input logic [1:0] len_sel);
        logic [CHAR_W-1:0] m;
        for (int i = 0; i < CHAR_W; i++) begin
            m[i] = (i < LEN_BASE + int'(len_sel));
        end
        return m;
    endfunction

    function automatic logic char_parity(input logic [CHAR_W-1:0] ch,
                                         input logic [1:0]        len_sel,
                                         input logic              odd);
        return (^(ch & char_mask(len_sel))) ^ odd;
    endfunction

endpackage

// File: rtl/dbtx_baudgen.sv
module dbtx_baudgen #(
    parameter int PRE_W = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       txc_tick,
    input  logic       sync_mode,
    input  logic [1:0] fac_sel,
    output logic       baud_tick
);
    import dbtx_pkg::*;

    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] last;
    logic             wrap;

    assign last      = PRE_W'(baud_div(fac_sel) - 1);
    assign wrap      = (pcnt >= last);
    assign baud_tick = txc_tick && (sync_mode || wrap);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
        end else if (txc_tick) begin
            pcnt <= wrap ? '0 : pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/dbtx_holdbuf.sv
module dbtx_holdbuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_stb,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr_stb && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/dbtx_shifter.sv
module dbtx_shifter
    import dbtx_pkg::*;
#(
    parameter int W = CHAR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  frame_cfg_t   cfg,
    input  logic [W-1:0] sync_char,
    input  logic         tx_en,
    input  logic         cts_n,
    input  logic         hold_full,
    input  logic [W-1:0] hold_data,
    output logic         take,
    output logic         txd,
    output logic         idle,
    output logic         on_fill
);
    localparam int CNT_W = $clog2(W);

    sh_state_e        st;
    logic [W-1:0]     sh;
    logic [CNT_W-1:0] left;
    logic             par_q;
    logic             fill_q;
    logic             txd_q;

    logic             go;
    logic             frame_end;
    logic             load_fill;
    logic [W-1:0]     next_char;
    logic             next_par;
    logic [CNT_W-1:0] first_left;

    assign go = tx_en && !cts_n;

    // current bit is the last one of its character
    always_comb begin
        case (st)
            SH_IDLE:  frame_end = 1'b1;
            SH_DATA:  frame_end = (left == '0) && !cfg.par_en && cfg.sync_mode;
            SH_PAR:   frame_end = cfg.sync_mode;
            SH_STOP1: frame_end = !cfg.two_stop;
            SH_STOP2: frame_end = 1'b1;
            default:  frame_end = 1'b0;
        endcase
    end

    assign take       = tick && frame_end && hold_full && go;
    assign load_fill  = tick && frame_end && !take && go && cfg.sync_mode;
    assign next_char  = take ? hold_data : sync_char;
    assign next_par   = char_parity(next_char, cfg.len_sel, cfg.par_odd);
    assign first_left = CNT_W'(LEN_BASE - 1 + int'(cfg.len_sel));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SH_IDLE;
            sh     <= '0;
            left   <= '0;
            par_q  <= 1'b0;
            fill_q <= 1'b0;
            txd_q  <= 1'b1;
        end else if (tick) begin
            if (frame_end) begin
                if (take || load_fill) begin
                    par_q  <= next_par;
                    fill_q <= load_fill;
                    if (cfg.sync_mode) begin
                        txd_q <= next_char[0];
                        sh    <= next_char >> 1;
                        left  <= first_left;
                        st    <= SH_DATA;
                    end else begin
                        txd_q <= 1'b0;
                        sh    <= next_char;
                        st    <= SH_START;
                    end
                end else begin
                    txd_q  <= 1'b1;
                    fill_q <= 1'b0;
                    st     <= SH_IDLE;
                end
            end else begin
                case (st)
                    SH_START: begin
                        txd_q <= sh[0];
                        sh    <= sh >> 1;
                        left  <= first_left;
                        st    <= SH_DATA;
                    end
                    SH_DATA: begin
                        if (left != '0) begin
                            txd_q <= sh[0];
                            sh    <= sh >> 1;
                            left  <= left - 1'b1;
                        end else if (cfg.par_en) begin
                            txd_q <= par_q;
                            st    <= SH_PAR;
                        end else begin
                            txd_q <= 1'b1;
                            st    <= SH_STOP1;
                        end
                    end
                    SH_PAR: begin
                        txd_q <= 1'b1;
                        st    <= SH_STOP1;
                    end
                    SH_STOP1: begin
                        txd_q <= 1'b1;
                        st    <= SH_STOP2;
                    end
                    default: begin
                        txd_q <= 1'b1;
                        st    <= SH_IDLE;
                    end
                endcase
            end
        end
    end

    assign txd     = txd_q;
    assign idle    = (st == SH_IDLE);
    assign on_fill = fill_q && (st != SH_IDLE);

endmodule

// File: rtl/dbuf_serial_tx.sv
module dbuf_serial_tx
    import dbtx_pkg::*;
#(
    parameter int PRE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txc_tick,
    input  logic              cfg_sync,
    input  logic [1:0]        cfg_factor,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic [CHAR_W-1:0] sync_char,
    input  logic              tx_en,
    input  logic              cts_n,
    input  logic              wr_stb,
    input  logic [CHAR_W-1:0] wr_data,
    output logic              txd,
    output logic              tx_rdy,
    output logic              tx_empty
);

    frame_cfg_t        fcfg;
    logic              baud_tick;
    logic              hold_full;
    logic [CHAR_W-1:0] hold_data;
    logic              take;
    logic              sh_idle;
    logic              sh_fill;

    assign fcfg = {cfg_sync, cfg_len, cfg_par_en, cfg_par_odd, cfg_two_stop};

    dbtx_baudgen #(.PRE_W(PRE_W)) u_baud (
        .clk       (clk),
        .rst       (rst),
        .txc_tick  (txc_tick),
        .sync_mode (cfg_sync),
        .fac_sel   (cfg_factor),
        .baud_tick (baud_tick)
    );

    dbtx_holdbuf #(.W(CHAR_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    dbtx_shifter #(.W(CHAR_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (baud_tick),
        .cfg       (fcfg),
        .sync_char (sync_char),
        .tx_en     (tx_en),
        .cts_n     (cts_n),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .take      (take),
        .txd       (txd),
        .idle      (sh_idle),
        .on_fill   (sh_fill)
    );

    assign tx_rdy   = !hold_full;
    assign tx_empty = !hold_full && (sh_idle || sh_fill);

endmodule

// File: rtl/dbtx_checker.sv
module dbtx_checker (
    input logic clk,
    input logic rst,
    input logic wr_stb,
    input logic tx_rdy,
    input logic tx_empty,
    input logic txd,
    input logic tx_en,
    input logic cts_n,
    input logic cfg_sync,
    input logic baud_tick,
    input logic sh_idle
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (txd && tx_rdy && tx_empty));

    a_r4_write_fills: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && tx_rdy) |=> !tx_rdy);

    a_r5_rdy_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_rdy) |-> $past(baud_tick));

    a_r6_blocked_mark: assert property (@(posedge clk) disable iff (rst)
        ((!tx_en || cts_n) && sh_idle) |=> txd);

    a_r8_empty_mark: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && !cfg_sync) |-> txd);

    a_r10_line_on_tick: assert property (@(posedge clk) disable iff (rst)
        !baud_tick |=> $stable(txd));

endmodule

bind dbuf_serial_tx dbtx_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (wr_stb),
    .tx_rdy    (tx_rdy),
    .tx_empty  (tx_empty),
    .txd       (txd),
    .tx_en     (tx_en),
    .cts_n     (cts_n),
    .cfg_sync  (cfg_sync),
    .baud_tick (baud_tick),
    .sh_idle   (sh_idle)
);

// File: tb/dbuf_serial_tx_test.sv
module dbuf_serial_tx_test;

    localparam int CLK_P = 10;
    localparam int CAP_N = 4096;
    localparam int NVEC  = 6;

    typedef struct packed {
        logic [7:0] ch;
        logic [1:0] len;
        logic       pe;
        logic       po;
        logic       ts;
        logic [1:0] fac;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{8'h35, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0},
        '{8'hB7, 2'd3, 1'b1, 1'b0, 1'b0, 2'd1},
        '{8'h0F, 2'd0, 1'b1, 1'b1, 1'b1, 2'd0},
        '{8'hE9, 2'd2, 1'b0, 1'b0, 1'b1, 2'd0},
        '{8'h6D, 2'd1, 1'b1, 1'b0, 1'b0, 2'd2},
        '{8'h00, 2'd3, 1'b1, 1'b1, 1'b1, 2'd0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       txc_tick = 1'b1;
    logic       cfg_sync = 1'b0;
    logic [1:0] cfg_factor = 2'd0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic [7:0] sync_char = 8'h16;
    logic       tx_en = 1'b1;
    logic       cts_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, tx_rdy, tx_empty;

    int errs = 0;
    int nchk = 0;
    int cyc = 0;

    // bench model of the bit clock, from R2
    int   bfac = 1;
    int   bcnt = 0;
    logic bt_seen = 1'b0;
    logic rst_seen = 1'b1;
    logic txc_gap = 1'b0;
    int   gcnt = 0;

    logic cap [CAP_N];
    int   ncap = 0;
    logic cap_on = 1'b0;
    logic prev_txd = 1'b1;
    logic prev_ok = 1'b0;
    int   r10_bad = 0;
    int   run = 0;
    int   first_run = 0;

    dbuf_serial_tx uut (
        .clk          (clk),
        .rst          (rst),
        .txc_tick     (txc_tick),
        .cfg_sync     (cfg_sync),
        .cfg_factor   (cfg_factor),
        .cfg_len      (cfg_len),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_two_stop (cfg_two_stop),
        .sync_char    (sync_char),
        .tx_en        (tx_en),
        .cts_n        (cts_n),
        .wr_stb       (wr_stb),
        .wr_data      (wr_data),
        .txd          (txd),
        .tx_rdy       (tx_rdy),
        .tx_empty     (tx_empty)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        rst_seen <= rst;
        if (rst) begin
            bcnt    <= 0;
            bt_seen <= 1'b0;
        end else begin
            bt_seen <= txc_tick && (cfg_sync || bcnt >= bfac - 1);
            if (txc_tick) bcnt <= (bcnt >= bfac - 1) ? 0 : bcnt + 1;
        end
    end

    always @(negedge clk) begin
        if (txc_gap) begin
            txc_tick = (gcnt == 0);
            gcnt     = (gcnt == 2) ? 0 : gcnt + 1;
        end else begin
            txc_tick = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (cap_on && bt_seen && ncap < CAP_N) begin
            cap[ncap] = txd;
            ncap++;
        end
        if (rst_seen) begin
            prev_ok = 1'b0;
        end else begin
            if (prev_ok && !bt_seen && txd !== prev_txd) r10_bad++;
            prev_ok = 1'b1;
        end
        prev_txd = txd;
        if (cap_on) begin
            if (txd === 1'b0) begin
                run++;
            end else begin
                if (run > 0 && first_run == 0) first_run = run;
                run = 0;
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errs++;
            nchk++;
            $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic sy, input logic [1:0] len, input logic pe,
                            input logic po, input logic ts, input logic [1:0] fac,
                            input logic en, input logic ctsn);
        @(negedge clk);
        cfg_sync = sy; cfg_len = len; cfg_par_en = pe; cfg_par_odd = po;
        cfg_two_stop = ts; cfg_factor = fac; tx_en = en; cts_n = ctsn;
        bfac = (fac == 2'd0) ? 1 : (fac == 2'd1) ? 16 : 64;
        rst = 1'b1; cap_on = 1'b0; wr_stb = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0; ncap = 0; run = 0; first_run = 0; cap_on = 1'b1;
    endtask

    task automatic send(input logic [7:0] ch);
        @(negedge clk);
        wr_stb = 1'b1; wr_data = ch;
        @(negedge clk);
        wr_stb = 1'b0;
        chk(tx_rdy === 1'b0, "R4 accepted write clears ready", tx_rdy, 0);
    endtask

    function automatic logic bpar(input logic [7:0] ch, input int L, input logic odd);
        logic [7:0] m;
        m = 8'((1 << L) - 1);
        return (^(ch & m)) ^ odd;
    endfunction

    task automatic decode_async(input int from, input int L, input logic pe, input logic ts,
                                output bit found, output logic [7:0] d, output logic p,
                                output bit stop_ok, output int st, output int nxt);
        int i;
        i = from; found = 0; d = 8'h00; p = 1'b0; stop_ok = 0; st = -1; nxt = from;
        while (i < ncap && cap[i] === 1'b1) i++;
        if (i + 2 + L + int'(pe) + int'(ts) > ncap) return;
        found = 1; st = i;
        for (int b = 0; b < L; b++) d[b] = cap[i + 1 + b];
        i = i + 1 + L;
        if (pe) begin p = cap[i]; i++; end
        stop_ok = (cap[i] === 1'b1); i++;
        if (ts) begin stop_ok = stop_ok && (cap[i] === 1'b1); i++; end
        nxt = i;
    endtask

    initial begin
        vec_t       t;
        int         L, F, s1, n1, s2, n2, s3, n3, nfr, n_dat, n_bad;
        bit         f1, f2, f3, ok1, ok2, ok3;
        logic [7:0] d1, d2, d3, fr;
        logic       p1, p2, p3;
        logic [5:0] sp;

        // reset state
        do_reset(1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
        chk(txd === 1'b1, "R1 reset txd", txd, 1);
        chk(tx_rdy === 1'b1, "R1 reset tx_rdy", tx_rdy, 1);
        chk(tx_empty === 1'b1, "R1 reset tx_empty", tx_empty, 1);

        // vector table: one asynchronous frame per entry
        for (int v = 0; v < NVEC; v++) begin
            t = VECS[v];
            L = 5 + int'(t.len);
            F = (t.fac == 2'd0) ? 1 : (t.fac == 2'd1) ? 16 : 64;
            do_reset(1'b0, t.len, t.pe, t.po, t.ts, t.fac, 1'b1, 1'b0);
            send(t.ch);
            repeat ((L + 6) * F + 10) @(negedge clk);
            decode_async(0, L, t.pe, t.ts, f1, d1, p1, ok1, s1, n1);
            chk(f1, "R3 frame found", f1, 1);
            chk(d1 === (t.ch & 8'((1 << L) - 1)), "R3 data bits", d1, t.ch & 8'((1 << L) - 1));
            if (t.pe) chk(p1 === bpar(t.ch, L, t.po), "R3 parity bit", p1, bpar(t.ch, L, t.po));
            chk(ok1, "R3 stop bits", ok1, 1);
            chk(n1 - s1 == 2 + L + int'(t.pe) + int'(t.ts), "R3 frame length", n1 - s1,
                2 + L + int'(t.pe) + int'(t.ts));
            if (t.ch[0]) chk(first_run == F, "R2 start bit cycles", first_run, F);
            chk(tx_empty === 1'b1, "R8 empty after frame", tx_empty, 1);
            chk(txd === 1'b1, "R8 line at mark", txd, 1);
        end

        // double buffering and back-to-back frames
        do_reset(1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
        send(8'h3C);
        chk(tx_empty === 1'b0, "R8 not empty while held", tx_empty, 0);
        @(negedge clk);
        chk(tx_rdy === 1'b1, "R5 ready returns at transfer", tx_rdy, 1);
        chk(txd === 1'b0, "R5 start bit at transfer", txd, 0);
        chk(tx_empty === 1'b0, "R8 not empty while shifting", tx_empty, 0);
        send(8'hC5);
        @(negedge clk);
        wr_stb = 1'b1; wr_data = 8'hFF;
        @(negedge clk);
        wr_stb = 1'b0;
        chk(tx_rdy === 1'b0, "R4 write while full leaves ready low", tx_rdy, 0);
        repeat (40) @(negedge clk);
        decode_async(0, 8, 1'b0, 1'b0, f1, d1, p1, ok1, s1, n1);
        chk(f1 && d1 === 8'h3C, "R5 first frame", d1, 8'h3C);
        decode_async(n1, 8, 1'b0, 1'b0, f2, d2, p2, ok2, s2, n2);
        chk(f2 && d2 === 8'hC5, "R5 second frame", d2, 8'hC5);
        chk(s2 == n1, "R5 no gap between frames", s2, n1);
        decode_async(n2, 8, 1'b0, 1'b0, f3, d3, p3, ok3, s3, n3);
        chk(!f3, "R4 write while full dropped", f3, 0);
        chk(tx_empty === 1'b1, "R8 empty at end", tx_empty, 1);

        // reset in the middle of a frame
        send(8'h55);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(txd === 1'b1 && tx_rdy === 1'b1 && tx_empty === 1'b1, "R1 reset mid-frame",
            {txd, tx_rdy, tx_empty}, 3'b111);
        rst = 1'b0;

        // clear-to-send holds a character
        do_reset(1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1);
        send(8'h5A);
        repeat (30) @(negedge clk);
        n_bad = 0;
        for (int i = 0; i < ncap; i++) if (cap[i] !== 1'b1) n_bad++;
        chk(n_bad == 0, "R6 line at mark while cts high", n_bad, 0);
        chk(tx_rdy === 1'b0 && tx_empty === 1'b0, "R6 character held", {tx_rdy, tx_empty}, 0);
        cts_n = 1'b0;
        repeat (20) @(negedge clk);
        decode_async(0, 8, 1'b0, 1'b0, f1, d1, p1, ok1, s1, n1);
        chk(f1 && d1 === 8'h5A, "R6 sent after cts low", d1, 8'h5A);

        // enable holds a character
        do_reset(1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
        send(8'h99);
        repeat (30) @(negedge clk);
        chk(txd === 1'b1 && tx_rdy === 1'b0, "R6 held while disabled", {txd, tx_rdy}, 2'b10);
        tx_en = 1'b1;
        repeat (20) @(negedge clk);
        decode_async(0, 8, 1'b0, 1'b0, f1, d1, p1, ok1, s1, n1);
        chk(f1 && d1 === 8'h99, "R6 sent after enable", d1, 8'h99);

        // cts rises mid-character
        do_reset(1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
        send(8'h81);
        send(8'h42);
        repeat (3) @(negedge clk);
        cts_n = 1'b1;
        repeat (40) @(negedge clk);
        decode_async(0, 8, 1'b0, 1'b0, f1, d1, p1, ok1, s1, n1);
        chk(f1 && ok1 && d1 === 8'h81, "R7 current character completes", d1, 8'h81);
        decode_async(n1, 8, 1'b0, 1'b0, f2, d2, p2, ok2, s2, n2);
        chk(!f2, "R7 next character held", f2, 0);
        chk(tx_rdy === 1'b0, "R7 held character keeps ready low", tx_rdy, 0);
        cts_n = 1'b0;
        repeat (20) @(negedge clk);
        decode_async(n1, 8, 1'b0, 1'b0, f2, d2, p2, ok2, s2, n2);
        chk(f2 && d2 === 8'h42, "R7 held character sent later", d2, 8'h42);

        // synchronous mode with gapped transmit clock, factor ignored
        txc_gap = 1'b1;
        sync_char = 8'h16;
        do_reset(1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0);
        repeat (80) @(negedge clk);
        chk(tx_empty === 1'b1, "R9 empty while filling", tx_empty, 1);
        send(8'hA5);
        chk(tx_empty === 1'b0, "R9 not empty with data held", tx_empty, 0);
        repeat (200) @(negedge clk);
        cap_on = 1'b0;
        nfr = ncap / 8; n_dat = 0; n_bad = 0;
        for (int f = 0; f < nfr; f++) begin
            for (int b = 0; b < 8; b++) fr[b] = cap[f * 8 + b];
            if (fr === 8'hA5) n_dat++;
            else if (fr !== 8'h16) n_bad++;
            if (f == 0) chk(fr === 8'h16, "R9 first frame is fill", fr, 8'h16);
        end
        chk(n_dat == 1, "R9 data frame once", n_dat, 1);
        chk(n_bad == 0, "R2 one bit per tick, no stray frames", n_bad, 0);
        chk(tx_empty === 1'b1, "R9 empty after data sent", tx_empty, 1);
        txc_gap = 1'b0;

        // synchronous 5-bit with even parity
        do_reset(1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
        repeat (12) @(negedge clk);
        for (int b = 0; b < 6; b++) sp[b] = cap[b];
        chk(sp === 6'b110110, "R9 fill with parity, no framing", sp, 6'b110110);

        // synchronous, disabled: mark
        do_reset(1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        n_bad = 0;
        for (int i = 0; i < ncap; i++) if (cap[i] !== 1'b1) n_bad++;
        chk(n_bad == 0 && tx_empty === 1'b1, "R6 sync disabled idles at mark", n_bad, 0);

        chk(r10_bad == 0, "R10 line changes only on ticks", r10_bad, 0);
        finish_run();
    end

endmodule